// File: doc/BRIEF.md
# Iterative DES Round Unit

This block computes the Data Encryption Standard one round at a time. It holds a 64-bit data block and a 64-bit key in two banks of eight byte registers that stay visible through a byte-wide read and write port. Software loads both banks, then issues sixteen single-cycle round commands. Each command carries a 4-bit round number and a direction bit. After each command the banks hold the intermediate block and the rotated key. After the last round the data bank holds the ciphertext or the plaintext, and the key bank holds the original key again.

Round 0 applies the initial permutation before its Feistel step. Round 15 swaps the halves and applies the final permutation after its Feistel step. The per-round subkey is formed from the stored key on the fly. The stored key is rotated left for encryption and right for decryption by the standard schedule, so a second block can start right away without reloading the key. Parity bits pass through untouched and have no effect on the cipher.

Top module: `des_round_unit`

## Requirements
- R1: After reset every byte of the data bank and of the key bank reads as zero.
- R2: A write with `wr_en` high stores `wr_data` into byte `wr_addr` of the key bank when `wr_key` is 1, or of the data bank when it is 0. The byte is readable on `rd_data` in the next cycle. Byte i holds bits 8i+7..8i of the 64-bit word, so bit 63 of the word is the first bit of DES.
- R3: With `cmd_decrypt` low, sixteen commands with `cmd_round` 0 to 15 turn the data bank into the DES encryption of the loaded block under the loaded key.
- R4: With `cmd_decrypt` high, sixteen commands with `cmd_round` 0 to 15 turn the data bank into the DES decryption of the loaded block. The direction is held constant within one block.
- R5: Each command updates both banks at the clock edge that samples it. After round 0 the data bank holds the left half after the initial permutation and the first round in bits 63..32, and the right half in bits 31..0. Idle cycles between commands do not change the result.
- R6: After round 15 the key bank equals the key that was present before round 0, in either direction.
- R7: The key parity bits (bit 0 of every key byte) do not change any result, and no round alters them.
- R8: A byte write presented in the same cycle as a command is discarded. The command result is stored instead.
- R9: In a cycle with neither a command nor a write, both banks keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_key | input | 1 | Write target: 1 key bank, 0 data bank |
| wr_addr | input | 3 | Byte index of the write |
| wr_data | input | 8 | Byte written |
| rd_key | input | 1 | Read source: 1 key bank, 0 data bank |
| rd_addr | input | 3 | Byte index of the read |
| rd_data | output | 8 | Byte read, combinational from the bank |
| cmd_valid | input | 1 | Round command strobe |
| cmd_round | input | 4 | Round number of the command |
| cmd_decrypt | input | 1 | Direction: 1 decrypt, 0 encrypt |

## Verification
The assertions assume that the caller issues round commands as a strict 0-to-15 sequence and never skips or repeats a round. They also assume that the direction bit stays the same from round 0 to round 15. They check both conditions on the inputs rather than tolerate a violation. The bench meets these assumptions by sending every block through one task that always issues all sixteen rounds in order with a fixed direction. Idle gaps and stray writes are inserted only between or alongside in-order commands. Loads and readbacks occur only outside a running block, or in the one scenario where a write is meant to collide with a command.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int BLK_W   = 64;
  localparam int HALF_W  = 32;
  localparam int CD_W    = 56;
  localparam int SUB_W   = 48;
  localparam int NBYTES  = BLK_W / 8;
  localparam int ROUND_W = 4;

  localparam int IP_T [64] = '{
    58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
    62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
    57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
    61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

  localparam int E_T [48] = '{
    32,1,2,3,4,5,     4,5,6,7,8,9,       8,9,10,11,12,13,   12,13,14,15,16,17,
    16,17,18,19,20,21, 20,21,22,23,24,25, 24,25,26,27,28,29, 28,29,30,31,32,1};

  localparam int P_T [32] = '{
    16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
    2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

  localparam int PC1_T [56] = '{
    57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
    10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
    63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
    14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

  localparam int PC2_T [48] = '{
    14,17,11,24,1,5,   3,28,15,6,21,10,   23,19,12,4,26,8,   16,7,27,20,13,2,
    41,52,31,37,47,55, 30,40,51,45,33,48, 44,49,39,56,34,53, 46,42,50,36,29,32};

  localparam int SB1 [64] = '{
    14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,  0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,  15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int SB2 [64] = '{
    15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,  3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,  13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int SB3 [64] = '{
    10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,  13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,  1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int SB4 [64] = '{
    7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,  13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,  3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int SB5 [64] = '{
    2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,  14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,  11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int SB6 [64] = '{
    12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,  10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,  4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int SB7 [64] = '{
    4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,  13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,  6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int SB8 [64] = '{
    13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,  1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,  2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  // Tables count bits from 1 at the MSB; vector index = width - table entry.
  function automatic logic [BLK_W-1:0] perm_initial(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-IP_T[i]];
    return y;
  endfunction

  // Final permutation computed as the inverse of the initial one.
  function automatic logic [BLK_W-1:0] perm_final(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-IP_T[i]] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] expand_half(input logic [HALF_W-1:0] x);
    logic [SUB_W-1:0] y;
    for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = x[HALF_W-E_T[i]];
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] perm_p(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_T[i]];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] choice_one(input logic [BLK_W-1:0] k);
    logic [CD_W-1:0] y;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[BLK_W-PC1_T[i]];
    return y;
  endfunction

  // Scatters the rotated halves back to the key positions; parity bits kept.
  function automatic logic [BLK_W-1:0] choice_one_back(input logic [CD_W-1:0] cd,
                                                       input logic [BLK_W-1:0] k_old);
    logic [BLK_W-1:0] y;
    y = k_old;
    for (int i = 0; i < CD_W; i++) y[BLK_W-PC1_T[i]] = cd[CD_W-1-i];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] choice_two(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] y;
    for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = cd[CD_W-PC2_T[i]];
    return y;
  endfunction

  function automatic logic [3:0] sbox_lookup(input int box, input logic [5:0] b);
    int idx;
    int v;
    idx = int'({b[5], b[0], b[4:1]});
    case (box)
      0: v = SB1[idx];
      1: v = SB2[idx];
      2: v = SB3[idx];
      3: v = SB4[idx];
      4: v = SB5[idx];
      5: v = SB6[idx];
      6: v = SB7[idx];
      default: v = SB8[idx];
    endcase
    return 4'(v);
  endfunction

  function automatic logic [HALF_W-1:0] feistel_f(input logic [HALF_W-1:0] r,
                                                  input logic [SUB_W-1:0] k);
    logic [SUB_W-1:0]  e;
    logic [HALF_W-1:0] s;
    e = expand_half(r) ^ k;
    for (int b = 0; b < 8; b++) s[HALF_W-1-4*b -: 4] = sbox_lookup(b, e[SUB_W-1-6*b -: 6]);
    return perm_p(s);
  endfunction

  // Rotation amount for schedule step n: one position at steps 0, 1, 8, 15.
  function automatic logic step_is_two(input logic [ROUND_W-1:0] n);
    return !(n == 4'd0 || n == 4'd1 || n == 4'd8 || n == 4'd15);
  endfunction

  function automatic logic [27:0] rot_left(input logic [27:0] h, input logic two);
    return two ? {h[25:0], h[27:26]} : {h[26:0], h[27]};
  endfunction

  function automatic logic [27:0] rot_right(input logic [27:0] h, input logic two);
    return two ? {h[1:0], h[27:2]} : {h[0], h[27:1]};
  endfunction

endpackage

// File: rtl/des_byte_bank.sv
module des_byte_bank
  import des_pkg::*;
#(
  parameter int N_BYTES = 8,
  localparam int AW = $clog2(N_BYTES),
  localparam int WW = 8 * N_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          load_en,
  input  logic [WW-1:0] load_word,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic [WW-1:0] word
);

  logic [7:0] bytes_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bytes_q[g] <= '0;
      else if (load_en) bytes_q[g] <= load_word[8*g +: 8];
      else if (hit)     bytes_q[g] <= wr_data;
    end
    assign word[8*g +: 8] = bytes_q[g];
  end

  assign rd_byte = bytes_q[rd_addr];

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !wr_en) |=> $stable(word)); // R9

  AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (word == $past(load_word))); // R8

endmodule

// File: rtl/des_key_step.sv
module des_key_step
  import des_pkg::*;
(
  input  logic [BLK_W-1:0]   key_in,
  input  logic [ROUND_W-1:0] round,
  input  logic               decrypt,
  output logic [SUB_W-1:0]   subkey,
  output logic [BLK_W-1:0]   key_out
);

  logic [CD_W-1:0] cd_now;
  logic [CD_W-1:0] cd_left;
  logic [CD_W-1:0] cd_right;
  logic [CD_W-1:0] cd_next;
  logic            enc_two;
  logic            dec_two;

  assign cd_now  = choice_one(key_in);
  assign enc_two = step_is_two(round);
  assign dec_two = step_is_two(~round);

  assign cd_left  = {rot_left(cd_now[55:28], enc_two),  rot_left(cd_now[27:0], enc_two)};
  assign cd_right = {rot_right(cd_now[55:28], dec_two), rot_right(cd_now[27:0], dec_two)};

  // Encrypt: rotate first, then select. Decrypt: select, then rotate back.
  assign cd_next = decrypt ? cd_right : cd_left;
  assign subkey  = decrypt ? choice_two(cd_now) : choice_two(cd_left);
  assign key_out = choice_one_back(cd_next, key_in);

endmodule

// File: rtl/des_data_step.sv
module des_data_step
  import des_pkg::*;
(
  input  logic [BLK_W-1:0]   blk_in,
  input  logic [ROUND_W-1:0] round,
  input  logic [SUB_W-1:0]   subkey,
  output logic [BLK_W-1:0]   blk_out,
  output logic               first_round,
  output logic               last_round
);

  logic [BLK_W-1:0]  pre;
  logic [HALF_W-1:0] l_in;
  logic [HALF_W-1:0] r_in;
  logic [HALF_W-1:0] r_new;

  assign first_round = (round == '0);
  assign last_round  = (round == '1);

  assign pre   = first_round ? perm_initial(blk_in) : blk_in;
  assign l_in  = pre[BLK_W-1:HALF_W];
  assign r_in  = pre[HALF_W-1:0];
  assign r_new = l_in ^ feistel_f(r_in, subkey);

  assign blk_out = last_round ? perm_final({r_new, r_in}) : {r_in, r_new};

endmodule

// File: rtl/des_round_unit.sv
module des_round_unit
  import des_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_key,
  input  logic [2:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic         rd_key,
  input  logic [2:0]   rd_addr,
  output logic [7:0]   rd_data,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_round,
  input  logic         cmd_decrypt
);

  logic [BLK_W-1:0] data_word;
  logic [BLK_W-1:0] key_word;
  logic [BLK_W-1:0] data_next;
  logic [BLK_W-1:0] key_next;
  logic [SUB_W-1:0] subkey;
  logic [7:0]       data_rd;
  logic [7:0]       key_rd;
  logic             first_round;
  logic             last_round;
  logic             block_done;

  des_byte_bank #(.N_BYTES(NBYTES)) data_bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wr_key), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_en(cmd_valid), .load_word(data_next),
    .rd_addr(rd_addr), .rd_byte(data_rd), .word(data_word)
  );

  des_byte_bank #(.N_BYTES(NBYTES)) key_bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_key), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_en(cmd_valid), .load_word(key_next),
    .rd_addr(rd_addr), .rd_byte(key_rd), .word(key_word)
  );

  des_key_step key_step_i (
    .key_in(key_word), .round(cmd_round), .decrypt(cmd_decrypt),
    .subkey(subkey), .key_out(key_next)
  );

  des_data_step data_step_i (
    .blk_in(data_word), .round(cmd_round), .subkey(subkey),
    .blk_out(data_next), .first_round(first_round), .last_round(last_round)
  );

  assign rd_data    = rd_key ? key_rd : data_rd;
  assign block_done = cmd_valid && last_round;

  // Observation state for the assertions below.
  logic [ROUND_W-1:0] next_round_q;
  logic               dir_q;
  logic [BLK_W-1:0]   key_snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_round_q <= '0;
      dir_q        <= 1'b0;
      key_snap_q   <= '0;
    end else if (cmd_valid) begin
      next_round_q <= cmd_round + 4'd1;
      if (first_round) begin
        dir_q      <= cmd_decrypt;
        key_snap_q <= key_word;
      end
    end
  end

  AST_ROUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_round == next_round_q)); // R5

  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !first_round) |-> (cmd_decrypt == dir_q)); // R4

  AST_KEY_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> (key_word == key_snap_q)); // R6

  AST_PARITY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> ((key_word & 64'h0101010101010101) ==
                   ($past(key_word) & 64'h0101010101010101))); // R7

endmodule

// File: tb/des_round_unit_tb_top.sv
module des_round_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_key = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_key = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_round = '0;
  logic       cmd_decrypt = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  des_round_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_key(wr_key), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_key(rd_key), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_round(cmd_round), .cmd_decrypt(cmd_decrypt)
  );

  localparam logic [63:0] K1 = 64'h133457799BBCDFF1;
  localparam logic [63:0] P1 = 64'h0123456789ABCDEF;
  localparam logic [63:0] C1 = 64'h85E813540F0AB405;
  localparam logic [63:0] K2 = 64'h0E329232EA6D0D73;
  localparam logic [63:0] P2 = 64'h8787878787878787;
  localparam logic [63:0] C2 = 64'h0000000000000000;
  localparam logic [63:0] C0 = 64'h8CA64DE9C1B123A7;
  localparam logic [63:0] PAR = 64'h0101010101010101;

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%016h expected=%016h", req, what, act, exp);
    end
  endtask

  task automatic write_word(input logic is_key, input logic [63:0] w);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_key = is_key; wr_addr = 3'(i); wr_data = w[8*i +: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_word(input logic is_key, output logic [63:0] w);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd_key = is_key; rd_addr = 3'(i);
      #0.5;
      w[8*i +: 8] = rd_data;
    end
  endtask

  // Issues rounds lo..hi back to back; optionally a colliding data write at round jam.
  task automatic issue_rounds(input logic dec, input int lo, input int hi, input int jam);
    for (int r = lo; r <= hi; r++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_round = 4'(r); cmd_decrypt = dec;
      if (r == jam) begin
        wr_en = 1'b1; wr_key = 1'b0; wr_addr = 3'd0; wr_data = 8'hFF;
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic run_block(input string req, input logic dec, input logic [63:0] key,
                           input logic [63:0] din, input logic [63:0] exp, input int jam);
    logic [63:0] got;
    write_word(1'b1, key);
    write_word(1'b0, din);
    issue_rounds(dec, 0, 15, jam);
    read_word(1'b0, got);
    check64(req, "block result", got, exp);
    read_word(1'b1, got);
    check64("R6", "key after round 15", got, key);
  endtask

  task automatic test_reset();
    logic [63:0] got;
    read_word(1'b0, got);
    check64("R1", "data bank after reset", got, 64'h0);
    read_word(1'b1, got);
    check64("R1", "key bank after reset", got, 64'h0);
  endtask

  task automatic test_readback();
    logic [63:0] got;
    write_word(1'b0, 64'hA1B2C3D4E5F60718);
    write_word(1'b1, 64'h1122334455667788);
    read_word(1'b0, got);
    check64("R2", "data byte readback", got, 64'hA1B2C3D4E5F60718);
    read_word(1'b1, got);
    check64("R2", "key byte readback", got, 64'h1122334455667788);
    repeat (5) @(negedge clk);
    read_word(1'b0, got);
    check64("R9", "data bank held while idle", got, 64'hA1B2C3D4E5F60718);
  endtask

  // Single steps round 0, checks {L1,R1}, then finishes with idle gaps.
  task automatic test_stepwise();
    logic [63:0] got;
    write_word(1'b1, K1);
    write_word(1'b0, P1);
    issue_rounds(1'b0, 0, 0, -1);
    read_word(1'b0, got);
    check64("R5", "state after round 0", got, 64'hF0AAF0AAEF4A6544);
    for (int r = 1; r < 16; r++) begin
      issue_rounds(1'b0, r, r, -1);
      repeat (2) @(negedge clk);
    end
    read_word(1'b0, got);
    check64("R5", "stepwise with idle gaps", got, C1);
  endtask

  task automatic test_parity();
    logic [63:0] got;
    run_block("R7", 1'b0, K1 ^ PAR, P1, C1, -1);
    read_word(1'b1, got);
    check64("R7", "parity bits kept", got & PAR, (K1 ^ PAR) & PAR);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_readback();
    run_block("R3", 1'b0, K1, P1, C1, -1);
    run_block("R4", 1'b1, K1, C1, P1, -1);
    run_block("R3", 1'b0, K2, P2, C2, -1);
    run_block("R4", 1'b1, K2, C2, P2, -1);
    run_block("R3", 1'b0, 64'h0, 64'h0, C0, -1);
    test_stepwise();
    test_parity();
    run_block("R8", 1'b0, K1, P1, C1, 5);
    run_block("R8", 1'b1, K1, C1, P1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule